// File: doc/BRIEF.md
# Control Register Write Unit

This block takes write requests aimed at a small processor control register file and turns them into legal register updates. The file holds a status word, two saved copies of that status word (one for breakpoint and one for debug entry), two modulo-addressing bound registers and a handful of general control slots. Each request names a register, carries new data, a keep mask and a flag saying whether the write comes from hardware (trap or debug entry) or from a software move instruction.

Before anything is stored, the block removes bits that may not be written. When the stack-mode bit of the status word is writable in a request, the block banks the current stack pointer and, if the mode actually flips, hands the other bank's pointer back to the general register file. It also raises an illegal-instruction flag when a request would leave the saturation bit set without the extended-accumulator bit. A register is written only when its value really changes; the filtered value, the exception flag, the commit decision and the stack pointer reload all appear combinationally in the request cycle, and the write lands on the next rising clock edge.

Top module: `ctlreg_wr_unit`

## Requirements
- R1: A bit set in `req_keep` leaves the matching register bit at its old value; only bits with a zero keep bit take the filtered request data, and `val_out` is zero wherever `req_keep` is one.
- R2: A software write (`req_hw`=0) to the status word (index 0) keeps only bits 15, 13, 12, 10, 9, 8, 7, 6, 3, 2 and 0 (software mask 0xB7CD); every other bit of `val_out` is zero.
- R3: Bit 11 (debug-mode) of a status-class register can be set only by a hardware write (`req_hw`=1, mask 0xBFCD); a software write always clears it in `val_out`.
- R4: Writes to the breakpoint copy (index 1) and debug copy (index 4) of the status word use the same software/hardware filtering as index 0.
- R5: When a request targets index 0 with `req_keep[15]`=0, `sp_cur` is saved into the bank selected by the old stack-mode bit (`psw_out[15]`); if the new bit differs, `sp_reload` is 1 and `sp_reload_data` is the contents of the bank selected by the new bit. With `req_keep[15]`=1 no bank is written and no reload occurs.
- R6: `illegal_out` is 1 exactly when a valid request to index 0 leaves bit 6 set and bit 7 clear in `val_out` with both `req_keep[6]` and `req_keep[7]` zero; the write itself still proceeds.
- R7: Writes to the modulo start (index 10) and modulo end (index 11) registers always clear bit 0.
- R8: Writes to any other index pass the data through unfiltered (apart from R1).
- R9: `commit_out` is 1 and the register is updated only when the register's unkept bits differ from `val_out`; otherwise the register is left untouched.
- R10: Synchronous active-high `rst` clears every register and both stack pointer banks.
- R11: An update is visible on `psw_out` right after the committing edge; `rd_data` returns the register chosen by `rd_idx` one clock edge after `rd_idx` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present this cycle |
| req_idx | input | 4 | Target register index |
| req_data | input | 16 | New data |
| req_keep | input | 16 | Keep mask, 1 = bit keeps its old value |
| req_hw | input | 1 | 1 = hardware-originated write |
| sp_cur | input | 16 | Current stack pointer from the register file |
| rd_idx | input | 4 | Read index |
| val_out | output | 16 | Filtered and unkept write value |
| illegal_out | output | 1 | Illegal-instruction flag |
| commit_out | output | 1 | This request updates the register |
| sp_reload | output | 1 | Stack pointer must be reloaded |
| sp_reload_data | output | 16 | Stack pointer value to reload |
| rd_data | output | 16 | Registered read data |
| psw_out | output | 16 | Current status word |

## Verification
`val_out`, `illegal_out`, `commit_out`, `sp_reload` and `sp_reload_data` are due in the request cycle itself, so the bench drives the request on the falling edge and samples them 2 ns later, before the rising edge. Register contents and bank saves take effect on that rising edge: `psw_out` is sampled just after it, and `rd_data` is sampled one further edge after `rd_idx` is applied. The effect of a bank save is read back only through the `sp_reload_data` of a later mode flip.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  // register indices whose filtering depends on the index
  localparam int unsigned IDX_PSW  = 0;
  localparam int unsigned IDX_BPSW = 1;
  localparam int unsigned IDX_DPSW = 4;
  localparam int unsigned IDX_MODS = 10;
  localparam int unsigned IDX_MODE = 11;

  // status word bit positions
  localparam int unsigned B_SM = 15;
  localparam int unsigned B_EA = 13;
  localparam int unsigned B_DB = 12;
  localparam int unsigned B_DM = 11;
  localparam int unsigned B_IE = 10;
  localparam int unsigned B_RP = 9;
  localparam int unsigned B_MD = 8;
  localparam int unsigned B_FX = 7;
  localparam int unsigned B_ST = 6;
  localparam int unsigned B_F0 = 3;
  localparam int unsigned B_F1 = 2;
  localparam int unsigned B_C  = 0;

  localparam logic [15:0] STATUS_SW_MASK =
      (16'(1) << B_SM) | (16'(1) << B_EA) | (16'(1) << B_DB) |
      (16'(1) << B_IE) | (16'(1) << B_RP) | (16'(1) << B_MD) |
      (16'(1) << B_FX) | (16'(1) << B_ST) | (16'(1) << B_F0) |
      (16'(1) << B_F1) | (16'(1) << B_C);

  localparam logic [15:0] STATUS_HW_MASK = STATUS_SW_MASK | (16'(1) << B_DM);

  typedef enum logic [1:0] {
    CR_PLAIN,
    CR_STATUS,
    CR_ALIGNED
  } cr_kind_e;

endpackage

// File: rtl/ctlreg_filter.sv
module ctlreg_filter
  import ctlreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] keep,
  input  logic              hw,
  output logic [DATA_W-1:0] val,
  output logic              is_psw,
  output logic              st_fault
);

  localparam logic [DATA_W-1:0] SW_M    = DATA_W'(STATUS_SW_MASK);
  localparam logic [DATA_W-1:0] HW_M    = DATA_W'(STATUS_HW_MASK);
  localparam logic [DATA_W-1:0] ALIGN_M = ~DATA_W'(1);

  cr_kind_e          kind;
  logic [DATA_W-1:0] raw;

  always_comb begin
    if (idx == IDX_W'(IDX_PSW) || idx == IDX_W'(IDX_BPSW) ||
        idx == IDX_W'(IDX_DPSW)) begin
      kind = CR_STATUS;
    end else if (idx == IDX_W'(IDX_MODS) || idx == IDX_W'(IDX_MODE)) begin
      kind = CR_ALIGNED;
    end else begin
      kind = CR_PLAIN;
    end
  end

  always_comb begin
    case (kind)
      CR_STATUS:  raw = data & (hw ? HW_M : SW_M);
      CR_ALIGNED: raw = data & ALIGN_M;
      default:    raw = data;
    endcase
    val = raw & ~keep;
  end

  always_comb begin
    is_psw   = (idx == IDX_W'(IDX_PSW));
    st_fault = is_psw && !keep[B_ST] && !keep[B_FX] && val[B_ST] && !val[B_FX];
  end

endmodule

// File: rtl/ctlreg_sp_bank.sv
module ctlreg_sp_bank #(
  parameter int DATA_W = 16,
  parameter int BANKS  = 2,
  localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              save_en,
  input  logic [SEL_W-1:0]  save_sel,
  input  logic [DATA_W-1:0] save_data,
  input  logic [SEL_W-1:0]  load_sel,
  output logic [DATA_W-1:0] load_data
);

  logic [DATA_W-1:0] bank_rd [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (save_en && save_sel == SEL_W'(g)) begin
        q <= save_data;
      end
    end
    assign bank_rd[g] = q;
  end

  assign load_data = bank_rd[load_sel];

endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [DATA_W-1:0] wr_keep,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              commit,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] psw
);

  logic [DATA_W-1:0] ent_rd [NUM_REGS];
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] nxt;

  assign cur    = ent_rd[wr_idx];
  assign commit = wr_en && ((cur & ~wr_keep) != wr_val);
  assign nxt    = (cur & wr_keep) | wr_val;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (commit && wr_idx == IDX_W'(g)) begin
        q <= nxt;
      end
    end
    assign ent_rd[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= ent_rd[rd_idx];
    end
  end

  assign psw = ent_rd[0];

endmodule

// File: rtl/ctlreg_wr_unit.sv
module ctlreg_wr_unit
  import ctlreg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] req_keep,
  input  logic              req_hw,
  input  logic [DATA_W-1:0] sp_cur,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] val_out,
  output logic              illegal_out,
  output logic              commit_out,
  output logic              sp_reload,
  output logic [DATA_W-1:0] sp_reload_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] psw_out
);

  logic is_psw;
  logic st_fault;
  logic sm_touch;
  logic sm_old;
  logic sm_new;

  ctlreg_filter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_filter (
    .idx      (req_idx),
    .data     (req_data),
    .keep     (req_keep),
    .hw       (req_hw),
    .val      (val_out),
    .is_psw   (is_psw),
    .st_fault (st_fault)
  );

  ctlreg_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_file (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (req_valid),
    .wr_idx  (req_idx),
    .wr_val  (val_out),
    .wr_keep (req_keep),
    .rd_idx  (rd_idx),
    .commit  (commit_out),
    .rd_data (rd_data),
    .psw     (psw_out)
  );

  assign sm_old   = psw_out[B_SM];
  assign sm_new   = val_out[B_SM];
  assign sm_touch = req_valid && is_psw && !req_keep[B_SM];

  ctlreg_sp_bank #(.DATA_W(DATA_W), .BANKS(2)) u_sp_bank (
    .clk       (clk),
    .rst       (rst),
    .save_en   (sm_touch),
    .save_sel  (sm_old),
    .save_data (sp_cur),
    .load_sel  (sm_new),
    .load_data (sp_reload_data)
  );

  assign sp_reload   = sm_touch && (sm_new != sm_old);
  assign illegal_out = req_valid && st_fault;

endmodule

// File: rtl/ctlreg_checker.sv
module ctlreg_checker
  import ctlreg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [IDX_W-1:0]  req_idx,
  input logic [DATA_W-1:0] req_keep,
  input logic              req_hw,
  input logic [DATA_W-1:0] val_out,
  input logic              illegal_out,
  input logic              commit_out,
  input logic              sp_reload,
  input logic [DATA_W-1:0] psw_out
);

  localparam logic [DATA_W-1:0] HW_M = DATA_W'(STATUS_HW_MASK);

  logic status_req;
  logic mod_req;
  logic psw_req;
  assign psw_req    = req_valid && req_idx == IDX_W'(IDX_PSW);
  assign status_req = req_valid && (req_idx == IDX_W'(IDX_PSW) ||
                      req_idx == IDX_W'(IDX_BPSW) || req_idx == IDX_W'(IDX_DPSW));
  assign mod_req    = req_valid && (req_idx == IDX_W'(IDX_MODS) ||
                      req_idx == IDX_W'(IDX_MODE));

  AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    psw_req |=> ((psw_out ^ $past(psw_out)) & $past(req_keep)) == '0); // R1

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_req |-> (val_out & ~HW_M) == '0); // R2

  AST_DM_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (status_req && !req_hw) |-> !val_out[B_DM]); // R3

  AST_RELOAD_ON_FLIP: assert property (@(posedge clk) disable iff (rst)
    sp_reload |-> (psw_req && !req_keep[B_SM] && val_out[B_SM] != psw_out[B_SM])); // R5

  AST_ILLEGAL_COMBO: assert property (@(posedge clk) disable iff (rst)
    illegal_out |-> (psw_req && val_out[B_ST] && !val_out[B_FX])); // R6

  AST_MOD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mod_req |-> !val_out[0]); // R7

  AST_NO_COMMIT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (psw_req && !commit_out) |=> $stable(psw_out)); // R9

  AST_COMMIT_CHANGES: assert property (@(posedge clk) disable iff (rst)
    (psw_req && commit_out) |=> psw_out != $past(psw_out)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> psw_out == '0); // R10

endmodule

bind ctlreg_wr_unit ctlreg_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/tb_ctlreg_wr_unit.sv
module tb_ctlreg_wr_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [3:0]  req_idx;
  logic [15:0] req_data;
  logic [15:0] req_keep;
  logic        req_hw;
  logic [15:0] sp_cur;
  logic [3:0]  rd_idx;
  logic [15:0] val_out;
  logic        illegal_out;
  logic        commit_out;
  logic        sp_reload;
  logic [15:0] sp_reload_data;
  logic [15:0] rd_data;
  logic [15:0] psw_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model [16];

  always #4 clk = ~clk;

  ctlreg_wr_unit dut (.*);

  // {idx, data, keep, hw, expected val, expected illegal}
  localparam int NV = 14;
  localparam logic [53:0] VEC [NV] = '{
    {4'd0,  16'hFFFF, 16'h8000, 1'b0, 16'h37CD, 1'b0},
    {4'd0,  16'hFFFF, 16'h8000, 1'b1, 16'h3FCD, 1'b0},
    {4'd0,  16'h0040, 16'h8000, 1'b0, 16'h0040, 1'b1},
    {4'd0,  16'h0040, 16'h8080, 1'b0, 16'h0040, 1'b0},
    {4'd1,  16'hFFFF, 16'h0000, 1'b0, 16'hB7CD, 1'b0},
    {4'd4,  16'hFFFF, 16'h0000, 1'b1, 16'hBFCD, 1'b0},
    {4'd4,  16'h0840, 16'h0000, 1'b0, 16'h0040, 1'b0},
    {4'd10, 16'h1235, 16'h0000, 1'b0, 16'h1234, 1'b0},
    {4'd11, 16'hFFFF, 16'h00F0, 1'b1, 16'hFF0E, 1'b0},
    {4'd2,  16'hABCD, 16'h0000, 1'b0, 16'hABCD, 1'b0},
    {4'd15, 16'hFFFF, 16'h0F00, 1'b0, 16'hF0FF, 1'b0},
    {4'd2,  16'hABCD, 16'h0000, 1'b0, 16'hABCD, 1'b0},
    {4'd0,  16'h0000, 16'hFFFF, 1'b0, 16'h0000, 1'b0},
    {4'd1,  16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive a request on the falling edge; outputs are sampled 2 ns later
  task automatic drive(input logic [3:0] idx, input logic [15:0] d,
                       input logic [15:0] k, input logic hw, input logic [15:0] sp);
    @(negedge clk);
    req_valid = 1'b1;
    req_idx   = idx;
    req_data  = d;
    req_keep  = k;
    req_hw    = hw;
    sp_cur    = sp;
    #2;
  endtask

  task automatic rd_check(input logic [3:0] idx, input logic [15:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    rd_idx    = idx;
    @(posedge clk);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic sm_step(input logic [15:0] sp, input logic [15:0] d, input logic [15:0] k,
                         input logic exp_rl, input logic [15:0] exp_data, input string tag);
    drive(4'd0, d, k, 1'b0, sp);
    chk({tag, " reload"}, sp_reload, exp_rl);
    if (exp_rl) chk({tag, " reload data"}, sp_reload_data, exp_data);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_idx = '0; req_data = '0; req_keep = '0;
    req_hw = 1'b0; sp_cur = '0; rd_idx = '0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 psw after reset", psw_out, 16'h0000);
    rd_check(4'd4, 16'h0000, "R10 reg4 after reset");

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [3:0]  idx = VEC[v][53:50];
      logic [15:0] d   = VEC[v][49:34];
      logic [15:0] k   = VEC[v][33:18];
      logic        hw  = VEC[v][17];
      logic [15:0] ev  = VEC[v][16:1];
      logic        eil = VEC[v][0];
      logic        ec;
      string       tag;
      if (k != 16'h0000)                    tag = "R1";
      else if (idx == 4'd1 || idx == 4'd4)  tag = "R4";
      else if (idx == 4'd0)                 tag = hw ? "R3" : "R2";
      else if (idx == 4'd10 || idx == 4'd11) tag = "R7";
      else                                  tag = "R8";
      drive(idx, d, k, hw, 16'h0000);
      ec = ((model[idx] & ~k) != ev);
      chk({tag, " val"}, val_out, ev);
      chk("R6 illegal", illegal_out, eil);
      chk("R9 commit", commit_out, ec);
      @(posedge clk);
      #1;
      if (ec) model[idx] = (model[idx] & k) | ev;
      if (idx == 4'd0) chk("R11 psw_out after edge", psw_out, model[0]);
      rd_check(idx, model[idx], "R11 readback");
    end

    // illegal flag needs a valid request
    @(negedge clk);
    req_valid = 1'b0; req_idx = 4'd0; req_data = 16'h0040; req_keep = 16'h0000;
    #2;
    chk("R6 no request no flag", illegal_out, 1'b0);

    // stack bank swapping, status word now has SM=0 and both banks are 0
    sm_step(16'h1111, 16'h8000, 16'h7FFF, 1'b1, 16'h0000, "R5 a");
    chk("R5 sm set", psw_out[15], 1'b1);
    sm_step(16'h2222, 16'h0000, 16'h7FFF, 1'b1, 16'h1111, "R5 b");
    sm_step(16'h3333, 16'h0000, 16'h7FFF, 1'b0, 16'h0000, "R5 c");
    sm_step(16'h4444, 16'h8000, 16'h7FFF, 1'b1, 16'h2222, "R5 d");
    sm_step(16'h5555, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, "R5 e kept");
    chk("R1 sm kept", psw_out[15], 1'b1);
    sm_step(16'h6666, 16'h0000, 16'h7FFF, 1'b1, 16'h4444, "R5 f");
    sm_step(16'h7777, 16'h8000, 16'h7FFF, 1'b1, 16'h6666, "R5 g");

    // reset in mid run clears registers and banks
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R10 psw cleared", psw_out, 16'h0000);
    rd_check(4'd2, 16'h0000, "R10 reg2 cleared");
    sm_step(16'hAAAA, 16'h8000, 16'h7FFF, 1'b1, 16'h0000, "R10 bank cleared");

    @(negedge clk);
    req_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule